// File: doc/BRIEF.md
# Four-Lane Row Serializer with Scrambled Fast Outputs

The block turns one wide row of binary hit flags into four serial bit streams. A row is written into a holding register with a one-cycle load strobe. At the end of every frame of `ROW_BITS/LANES` fast cycles, the holding register moves into a working register. The working register is then shifted out while the next row is collected. Each lane owns one contiguous quarter of the row.

Every lane is built from two stages. In the first, `SUB` slow multiplexers each walk through one interleaved share of the lane's bits. Each takes one step per slow period, and a slow period lasts `SUB` fast cycles. These slow streams are registered and brought out unscrambled as test outputs. In the second stage, a fast `SUB`:1 multiplexer picks one slow register per fast cycle and registers the pick. On the way it XORs the bit with a frame-synchronous additive scrambler sequence, which a bypass input can switch off.

The block also outputs a divided clock and a frame marker, so a receiver can find the frame and slow-period boundaries.

Top module: `frame_serializer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `lane_out` and `test_out` are all zero and `frame_mark` is 1. With the bypass on, `lane_out` stays zero through the first five cycles after release, and `test_out` stays zero through the first four.
- R2: A high `row_load` copies `row_in` into the holding register at that clock edge. At the last cycle of each frame, the holding register is copied into the working register. A load in that same last cycle reaches the working register only one frame later.
- R3: `frame_mark` is 1 in exactly one cycle out of every 160, the first cycle of a frame. `slow_clk` repeats every 4 cycles: it is low in frame-relative cycles with c mod 4 in {0,1} and high when c mod 4 is in {2,3}.
- R4: Lane k carries row bits k*160 through k*160+159. Bit k*160 is sent first.
- R5: Let t = g-4, where g counts cycles since frame 0 started. During cycle g, `test_out[k*4+j]` shows bit k*160+b+j of the row that was working in frame t/160, where b is (t mod 160) rounded down to a multiple of 4. The value is held for a whole slow period and is never scrambled.
- R6: Bit i of a frame's lane appears on `lane_out` in cycle 160F+5+i, one fast cycle after the slow path presents it.
- R7: With the bypass off, the lane bit i of each frame is XORed with s[i]. The sequence is defined by s[0..6]=1 and s[n]=s[n-7] XOR s[n-6], which is the taps x^7+x^6+1. The sequence restarts at i=0 in every frame and is the same on all lanes.
- R8: `scr_bypass`, sampled at the edge that registers a lane bit, sends that bit unscrambled.
- R9: When several loads fall within one frame, the last one decides the next working row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_in | input | ROW_BITS | Row of hit flags to load |
| row_load | input | 1 | Strobe: capture `row_in` into the holding register |
| scr_bypass | input | 1 | 1 sends fast lanes unscrambled |
| lane_out | output | LANES | Fast serial lanes |
| test_out | output | LANES*SUB | Unscrambled slow-rate test streams, index k*SUB+j |
| slow_clk | output | 1 | Fast clock divided by SUB |
| frame_mark | output | 1 | High in the first cycle of every frame |

## Verification
The assertions assume that `row_load` and `scr_bypass` are synchronous to `clk` and may change at any cycle. They also assume that the bits of `row_in` matter only in a cycle where `row_load` is high. The stimulus drives every input on the falling edge, so each value is stable across the next rising edge. It places loads at the first cycle, in the middle, twice in one frame, and at the last cycle of a frame. It changes the bypass only on frame starts, so that frames straddle both settings. The bench keeps a per-cycle record of what it drove and derives every expected output bit from that record.

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
package ser_pkg;
  localparam int unsigned SCR_W = 7;
  localparam logic [SCR_W-1:0] SCR_SEED = 7'h7F;

  // one step of the x^7+x^6+1 generator; output taken from the MSB
  function automatic logic [SCR_W-1:0] scr_step(input logic [SCR_W-1:0] s);
    return {s[SCR_W-2:0], s[6] ^ s[5]};
  endfunction

  // position inside a lane of the bit presented by slow mux `phase` in `slot`
  function automatic int unsigned lane_pos(input int unsigned slot,
                                           input int unsigned phase,
                                           input int unsigned sub);
    return slot * sub + phase;
  endfunction
endpackage

// File: rtl/ser_frame_ctrl.sv
`timescale 1ns/1ps
module ser_frame_ctrl #(
  parameter int unsigned ROW_BITS = 640,
  parameter int unsigned SUB      = 4,
  parameter int unsigned SLOTS    = 40,
  parameter int unsigned PH_W     = 2,
  parameter int unsigned SL_W     = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                row_load,
  input  logic [ROW_BITS-1:0] row_in,
  output logic [ROW_BITS-1:0] work_row,
  output logic [PH_W-1:0]     phase,
  output logic [SL_W-1:0]     slot,
  output logic                slow_tick,
  output logic                frame_end,
  output logic                frame_mark,
  output logic                seed_now,
  output logic                slow_clk
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SUB - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(SUB / 2);
  localparam logic [SL_W-1:0] SL_LAST = SL_W'(SLOTS - 1);
  localparam logic [SL_W-1:0] SL_ONE  = SL_W'(1);

  logic [ROW_BITS-1:0] hold_row;

  assign slow_tick  = (phase == PH_LAST);
  assign frame_end  = slow_tick && (slot == SL_LAST);
  assign frame_mark = (phase == '0) && (slot == '0);
  assign seed_now   = (phase == '0) && (slot == SL_ONE);
  assign slow_clk   = (phase >= PH_HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      slot  <= '0;
    end else if (slow_tick) begin
      phase <= '0;
      slot  <= (slot == SL_LAST) ? '0 : slot + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_row <= '0;
    else if (row_load) hold_row <= row_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         work_row <= '0;
    else if (frame_end) work_row <= hold_row;
  end

  AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    row_load |=> hold_row == $past(row_in)); // R2
  AST_WORK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(work_row)); // R2
  AST_MARK_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> frame_mark); // R3
  AST_MARK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mark |=> !frame_mark); // R3
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    slow_tick |=> !slow_tick); // R3
endmodule

// File: rtl/ser_slow_mux.sv
`timescale 1ns/1ps
module ser_slow_mux
  import ser_pkg::*;
#(
  parameter int unsigned LANE_BITS = 160,
  parameter int unsigned SUB       = 4,
  parameter int unsigned SL_W      = 6,
  parameter int unsigned LB_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LANE_BITS-1:0] lane_bits,
  input  logic [SL_W-1:0]      slot,
  input  logic                 slow_tick,
  output logic [SUB-1:0]       slow_q
);
  for (genvar j = 0; j < SUB; j++) begin : g_sub
    logic [LB_W-1:0] pick;
    assign pick = LB_W'(lane_pos(32'(slot), j, SUB));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         slow_q[j] <= 1'b0;
      else if (slow_tick) slow_q[j] <= lane_bits[pick];
    end
  end

  AST_SLOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_tick |=> $stable(slow_q)); // R5
endmodule

// File: rtl/ser_scrambler.sv
`timescale 1ns/1ps
module ser_scrambler
  import ser_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic seed_now,
  output logic scr_bit
);
  logic [SCR_W-1:0] state;
  logic [SCR_W-1:0] cur;

  assign cur     = seed_now ? SCR_SEED : state;
  assign scr_bit = cur[SCR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SCR_SEED;
    else        state <= scr_step(cur);
  end

  AST_SEED_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    seed_now |=> state == 7'h7E); // R7
  AST_STATE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0); // R7
endmodule

// File: rtl/ser_fast_lane.sv
`timescale 1ns/1ps
module ser_fast_lane #(
  parameter int unsigned SUB  = 4,
  parameter int unsigned PH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SUB-1:0]  slow_q,
  input  logic [PH_W-1:0] phase,
  input  logic            scr_bit,
  input  logic            bypass,
  output logic            lane_q
);
  logic sel_bit;
  assign sel_bit = slow_q[phase];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_q <= 1'b0;
    else        lane_q <= sel_bit ^ (scr_bit & ~bypass);
  end

  AST_BYPASS_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> lane_q == $past(sel_bit)); // R8
endmodule

// File: rtl/frame_serializer.sv
`timescale 1ns/1ps
module frame_serializer #(
  parameter int unsigned ROW_BITS = 640,
  parameter int unsigned LANES    = 4,
  parameter int unsigned SUB      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ROW_BITS-1:0]   row_in,
  input  logic                  row_load,
  input  logic                  scr_bypass,
  output logic [LANES-1:0]      lane_out,
  output logic [LANES*SUB-1:0]  test_out,
  output logic                  slow_clk,
  output logic                  frame_mark
);
  localparam int unsigned LANE_BITS = ROW_BITS / LANES;
  localparam int unsigned SLOTS     = LANE_BITS / SUB;
  localparam int unsigned PH_W      = (SUB > 1) ? $clog2(SUB) : 1;
  localparam int unsigned SL_W      = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int unsigned LB_W      = (LANE_BITS > 1) ? $clog2(LANE_BITS) : 1;

  logic [ROW_BITS-1:0] work_row;
  logic [PH_W-1:0]     phase;
  logic [SL_W-1:0]     slot;
  logic                slow_tick;
  logic                frame_end;
  logic                seed_now;
  logic                scr_bit;

  ser_frame_ctrl #(
    .ROW_BITS(ROW_BITS), .SUB(SUB), .SLOTS(SLOTS), .PH_W(PH_W), .SL_W(SL_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .row_load(row_load), .row_in(row_in),
    .work_row(work_row), .phase(phase), .slot(slot), .slow_tick(slow_tick),
    .frame_end(frame_end), .frame_mark(frame_mark), .seed_now(seed_now),
    .slow_clk(slow_clk)
  );

  ser_scrambler u_scr (
    .clk(clk), .rst_n(rst_n), .seed_now(seed_now), .scr_bit(scr_bit)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SUB-1:0] slow_q;

    ser_slow_mux #(
      .LANE_BITS(LANE_BITS), .SUB(SUB), .SL_W(SL_W), .LB_W(LB_W)
    ) u_slow (
      .clk(clk), .rst_n(rst_n),
      .lane_bits(work_row[k*LANE_BITS +: LANE_BITS]),
      .slot(slot), .slow_tick(slow_tick), .slow_q(slow_q)
    );

    ser_fast_lane #(.SUB(SUB), .PH_W(PH_W)) u_fast (
      .clk(clk), .rst_n(rst_n), .slow_q(slow_q), .phase(phase),
      .scr_bit(scr_bit), .bypass(scr_bypass), .lane_q(lane_out[k])
    );

    assign test_out[k*SUB +: SUB] = slow_q;
  end
endmodule

// File: tb/tb_frame_serializer.sv
`timescale 1ns/1ps
module tb_frame_serializer;
  localparam int ROW  = 640;
  localparam int L    = 4;
  localparam int S    = 4;
  localparam int LB   = ROW / L;
  localparam int NFR  = 10;
  localparam int NCYC = NFR * LB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ROW-1:0] row_in = '0;
  logic row_load = 1'b0;
  logic scr_bypass = 1'b1;
  logic [L-1:0] lane_out;
  logic [L*S-1:0] test_out;
  logic slow_clk;
  logic frame_mark;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [ROW-1:0] work_m [0:NFR];
  logic [ROW-1:0] hold_m;
  bit byp_m [0:NCYC];
  bit s_seq [0:LB-1];

  always #2.5 clk = ~clk;

  frame_serializer #(.ROW_BITS(ROW), .LANES(L), .SUB(S)) dut (
    .clk(clk), .rst_n(rst_n), .row_in(row_in), .row_load(row_load),
    .scr_bypass(scr_bypass), .lane_out(lane_out), .test_out(test_out),
    .slow_clk(slow_clk), .frame_mark(frame_mark)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [ROW-1:0] pattern(input int f);
    logic [ROW-1:0] r;
    for (int b = 0; b < ROW; b++) begin
      case (f % 5)
        0: r[b] = ((b * 7 + f) % 11) < 5;
        1: r[b] = 1'b1;
        2: r[b] = (b % 2) == 1;
        3: r[b] = (b % 3) == 0;
        default: r[b] = (b == (f * 37) % ROW) || (b % 160 == 159);
      endcase
    end
    return r;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < LB; n++)
      s_seq[n] = (n < 7) ? 1'b1 : (s_seq[n-7] ^ s_seq[n-6]);
    work_m[0] = '0;
    hold_m = '0;

    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(lane_out == '0, "R1 lane in reset", int'(lane_out), 0);
    chk(test_out == '0, "R1 test in reset", int'(test_out), 0);
    chk(frame_mark == 1'b1, "R1 mark in reset", int'(frame_mark), 1);
    rst_n = 1'b1;

    for (int g = 0; g < NCYC; g++) begin
      int f, c;
      bit ld, byp;
      logic [ROW-1:0] rv;
      f = g / LB;
      c = g % LB;
      byp = (f < 4) || (f == 7);
      ld = 1'b0;
      rv = '0;
      if (f == 0 && c == 0)        begin ld = 1; rv = pattern(1); end
      if (f == 1 && c == 10)       begin ld = 1; rv = pattern(2); end
      if (f == 1 && c == 80)       begin ld = 1; rv = pattern(3); end // R9
      if (f == 2 && c == 159)      begin ld = 1; rv = pattern(4); end // R2
      if (f >= 4 && c == (f * 23) % LB) begin ld = 1; rv = pattern(f + 1); end
      row_load = ld;
      row_in = rv;
      scr_bypass = byp;
      byp_m[g] = byp;
      if (c == LB - 1 && f + 1 <= NFR) work_m[f+1] = hold_m;
      if (ld) hold_m = rv;

      // R3 framing outputs
      chk(frame_mark == (c == 0), "R3 frame_mark", int'(frame_mark), int'(c == 0));
      chk(slow_clk == ((c % 4) >= 2), "R3 slow_clk", int'(slow_clk), int'((c % 4) >= 2));

      if (g < 4) chk(test_out == '0, "R1 test after release", int'(test_out), 0);
      if (g < 5) chk(lane_out == '0, "R1 lane after release", int'(lane_out), 0);

      if (g >= 4) begin
        int t, fr, base;
        t = g - 4;
        fr = t / LB;
        base = (t % LB) - (t % 4);
        for (int k = 0; k < L; k++)
          for (int j = 0; j < S; j++) begin
            logic e;
            e = work_m[fr][k*LB + base + j];
            // R5 R2 R9 slow test stream
            chk(test_out[k*S+j] == e, "R5 test stream", int'(test_out[k*S+j]), int'(e));
          end
      end

      if (g >= 5) begin
        int t, fr, i;
        t = g - 5;
        fr = t / LB;
        i = t % LB;
        for (int k = 0; k < L; k++) begin
          logic e;
          e = work_m[fr][k*LB + i] ^ (byp_m[g-1] ? 1'b0 : s_seq[i]);
          if (byp_m[g-1])
            chk(lane_out[k] == e, "R8 R4 R6 lane plain", int'(lane_out[k]), int'(e));
          else
            chk(lane_out[k] == e, "R7 R4 R6 lane scrambled", int'(lane_out[k]), int'(e));
        end
      end
      @(negedge clk);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule